// File: doc/BRIEF.md
# Video Integer Min/Max Unit

This block is a 32-bit datapath that selects the smaller or larger of two integer operands. Before the comparison, each operand is pulled out of a byte, halfword or full-word lane of its source word and widened to 32 bits as signed or unsigned. Operand B comes either from a source word in the same way or from a 16-bit immediate. The two operands may be interpreted with different signedness. The block resolves that case with 32-bit comparators and a forcing rule, so no 33-bit comparator is needed.

After the min/max, an optional saturation step clamps the result into the range of the destination format. A secondary step then combines the clamped value with a third operand C. The secondary step is one of: accumulate, a second min or max against C, a merge of the low bits of the result into one field of C, or a plain pass-through. The output is registered by default, so a result appears one clock after its inputs.

Top module: `vmm_unit`

## Requirements
- R1: Lane code 0..3 selects byte 0..3 (bits 8k+7:8k), code 4 selects bits 15:0, code 5 selects bits 31:16, and code 6 (and the spare code 7) selects the full word. A selected byte or halfword is right-aligned, then sign-extended when the operand's signed flag is 1 and zero-extended otherwise.
- R2: When `b_from_reg` is 0, B is the 16-bit immediate. It is sign-extended to 32 bits when `b_signed` is 1 and zero-extended otherwise.
- R3: When `a_signed` equals `b_signed`, the result is the 32-bit minimum (`take_max`=0) or maximum (`take_max`=1) of A and B, compared with that shared signedness. The result takes that signedness.
- R4: When signedness differs, a maximum is an unsigned compare and gives an unsigned result. A minimum is a signed compare and gives a signed result. In both cases, if the unsigned operand has bit 31 set, that operand is the result.
- R5: With `saturate`=1, a signed destination (`dst_signed`=1) clamps an unsigned result to at most 0x7FFFFFFF. An unsigned destination clamps a signed result to at least 0. A result that already matches the destination signedness is not changed.
- R6: Secondary code 1 adds C with 32-bit wraparound. Code 2 takes the maximum and code 3 the minimum against C, compared signed when `dst_signed`=1 and unsigned otherwise.
- R7: Secondary codes 4, 5, 6 and 7 return C with one field replaced by the low bits of the result. The fields are bits 31:16, bits 15:0, bits 7:0 and bits 23:16 respectively.
- R8: Secondary code 0 passes the saturated min/max result through unchanged.
- R9: `result` is registered. It reflects the inputs present at the previous rising clock edge and is 0 after a synchronous active-high reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 32 | Source word for operand A |
| opb | input | 32 | Source word for operand B |
| opc | input | 32 | Third operand C for the secondary step |
| imm | input | 16 | Immediate used as B when `b_from_reg` is 0 |
| b_from_reg | input | 1 | 1: B taken from `opb`; 0: B from `imm` |
| a_lane | input | 3 | Lane code for A |
| a_signed | input | 1 | A interpreted as signed |
| b_lane | input | 3 | Lane code for B (used when B is from `opb`) |
| b_signed | input | 1 | B interpreted as signed |
| take_max | input | 1 | 1: maximum, 0: minimum |
| saturate | input | 1 | Enable clamping to the destination format |
| dst_signed | input | 1 | Destination format is signed |
| sec_op | input | 3 | Secondary operation code |
| result | output | 32 | Registered result |

## Verification
The hardest path to reach is mixed signedness with bit 31 set on the unsigned operand. Here the forcing rule overrides the comparator, and the outcome then passes through saturation. Random full words rarely line up with the matching sign flags, lane codes and saturation setting at the same time. The stimulus therefore sweeps every pairing of the four boundary words 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF under every sign combination, with and without saturation, and for both destination formats. It then covers every lane-code and secondary-code combination with random words.

// File: rtl/vmm_pkg.sv
package vmm_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = 8;
    localparam int IMM_W  = 16;
    localparam int LANE_W = 3;
    localparam int SEC_W  = 3;

    localparam logic [WORD_W-1:0] SMAX_WORD = {1'b0, {(WORD_W-1){1'b1}}};

    typedef enum logic [LANE_W-1:0] {
        LANE_B0  = 3'd0,
        LANE_B1  = 3'd1,
        LANE_B2  = 3'd2,
        LANE_B3  = 3'd3,
        LANE_H0  = 3'd4,
        LANE_H1  = 3'd5,
        LANE_W32 = 3'd6,
        LANE_SPR = 3'd7
    } lane_e;

    typedef enum logic [SEC_W-1:0] {
        SEC_PASS  = 3'd0,
        SEC_ADD   = 3'd1,
        SEC_MAX   = 3'd2,
        SEC_MIN   = 3'd3,
        SEC_INS_H = 3'd4,
        SEC_INS_L = 3'd5,
        SEC_INS_0 = 3'd6,
        SEC_INS_2 = 3'd7
    } sec_e;

    typedef struct packed {
        logic [WORD_W-1:0] val;
        logic              sgn;
    } oper_t;

    function automatic logic [WORD_W-1:0] widen_byte(logic [BYTE_W-1:0] v, logic s);
        return {{(WORD_W-BYTE_W){s & v[BYTE_W-1]}}, v};
    endfunction

    function automatic logic [WORD_W-1:0] widen_half(logic [HALF_W-1:0] v, logic s);
        return {{(WORD_W-HALF_W){s & v[HALF_W-1]}}, v};
    endfunction

    function automatic logic less_than(logic [WORD_W-1:0] x, logic [WORD_W-1:0] y, logic s);
        if (s) return $signed(x) < $signed(y);
        else   return x < y;
    endfunction

endpackage

// File: rtl/vmm_lane_ext.sv
module vmm_lane_ext
    import vmm_pkg::*;
(
    input  logic [WORD_W-1:0] src,
    input  logic [LANE_W-1:0] lane,
    input  logic              sgn,
    output oper_t             op
);
    logic [BYTE_W-1:0] byte_sel;
    logic [HALF_W-1:0] half_sel;
    lane_e             lane_q;

    assign lane_q   = lane_e'(lane);
    assign byte_sel = src[lane[1:0]*BYTE_W +: BYTE_W];
    assign half_sel = lane[0] ? src[WORD_W-1:HALF_W] : src[HALF_W-1:0];

    always_comb begin
        op.sgn = sgn;
        unique case (lane_q)
            LANE_B0, LANE_B1, LANE_B2, LANE_B3: op.val = widen_byte(byte_sel, sgn);
            LANE_H0, LANE_H1:                   op.val = widen_half(half_sel, sgn);
            default:                            op.val = src;
        endcase
    end
endmodule

// File: rtl/vmm_minmax_core.sv
module vmm_minmax_core
    import vmm_pkg::*;
(
    input  oper_t             opa,
    input  oper_t             opb,
    input  logic              take_max,
    input  logic              saturate,
    input  logic              dst_signed,
    output logic [WORD_W-1:0] clamped
);
    logic              mixed;
    logic              lt_u;
    logic              lt_s;
    logic              lt_same;
    logic [WORD_W-1:0] pick;
    logic [WORD_W-1:0] uns_side;
    logic              res_sgn;

    assign mixed    = opa.sgn ^ opb.sgn;
    assign lt_u     = less_than(opa.val, opb.val, 1'b0);
    assign lt_s     = less_than(opa.val, opb.val, 1'b1);
    assign lt_same  = opa.sgn ? lt_s : lt_u;
    assign uns_side = opa.sgn ? opb.val : opa.val;

    always_comb begin
        if (!mixed) begin
            res_sgn = opa.sgn;
            if (take_max) pick = lt_same ? opb.val : opa.val;
            else          pick = lt_same ? opa.val : opb.val;
        end else begin
            res_sgn = !take_max;
            if (take_max) pick = lt_u ? opb.val : opa.val;
            else          pick = lt_s ? opa.val : opb.val;
            if (uns_side[WORD_W-1]) pick = uns_side;
        end
    end

    always_comb begin
        clamped = pick;
        if (saturate) begin
            if (dst_signed && !res_sgn && pick[WORD_W-1])
                clamped = SMAX_WORD;
            else if (!dst_signed && res_sgn && pick[WORD_W-1])
                clamped = '0;
        end
    end
endmodule

// File: rtl/vmm_secondary.sv
module vmm_secondary
    import vmm_pkg::*;
(
    input  logic [WORD_W-1:0] mm,
    input  logic [WORD_W-1:0] opc,
    input  logic [SEC_W-1:0]  sec_op,
    input  logic              dst_signed,
    output logic [WORD_W-1:0] outv
);
    sec_e sec_q;
    logic c_lt;

    assign sec_q = sec_e'(sec_op);
    assign c_lt  = less_than(mm, opc, dst_signed);

    always_comb begin
        outv = opc;
        unique case (sec_q)
            SEC_PASS:  outv = mm;
            SEC_ADD:   outv = mm + opc;
            SEC_MAX:   outv = c_lt ? opc : mm;
            SEC_MIN:   outv = c_lt ? mm : opc;
            SEC_INS_H: outv[WORD_W-1:HALF_W]      = mm[HALF_W-1:0];
            SEC_INS_L: outv[HALF_W-1:0]           = mm[HALF_W-1:0];
            SEC_INS_0: outv[BYTE_W-1:0]           = mm[BYTE_W-1:0];
            SEC_INS_2: outv[HALF_W+BYTE_W-1:HALF_W] = mm[BYTE_W-1:0];
            default:   outv = mm;
        endcase
    end
endmodule

// File: rtl/vmm_unit.sv
module vmm_unit
    import vmm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [WORD_W-1:0] opc,
    input  logic [IMM_W-1:0]  imm,
    input  logic              b_from_reg,
    input  logic [LANE_W-1:0] a_lane,
    input  logic              a_signed,
    input  logic [LANE_W-1:0] b_lane,
    input  logic              b_signed,
    input  logic              take_max,
    input  logic              saturate,
    input  logic              dst_signed,
    input  logic [SEC_W-1:0]  sec_op,
    output logic [WORD_W-1:0] result
);
    oper_t             a_op;
    oper_t             b_reg_op;
    oper_t             b_op;
    logic [WORD_W-1:0] mm_val;
    logic [WORD_W-1:0] sec_val;

    vmm_lane_ext u_ext_a (.src(opa), .lane(a_lane), .sgn(a_signed), .op(a_op));
    vmm_lane_ext u_ext_b (.src(opb), .lane(b_lane), .sgn(b_signed), .op(b_reg_op));

    always_comb begin
        if (b_from_reg) b_op = b_reg_op;
        else begin
            b_op.sgn = b_signed;
            b_op.val = {{(WORD_W-IMM_W){b_signed & imm[IMM_W-1]}}, imm};
        end
    end

    vmm_minmax_core u_core (
        .opa(a_op), .opb(b_op), .take_max(take_max),
        .saturate(saturate), .dst_signed(dst_signed), .clamped(mm_val)
    );

    vmm_secondary u_sec (
        .mm(mm_val), .opc(opc), .sec_op(sec_op),
        .dst_signed(dst_signed), .outv(sec_val)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) result <= '0;
                else     result <= sec_val;
            end

            // R5: mixed-sign max is unsigned, so a signed clamp keeps bit 31 clear
            a_r5_clamp_high: assert property (@(posedge clk) disable iff (rst)
                (saturate && dst_signed && (a_signed != b_signed) && take_max && sec_op == 3'd0)
                |=> !result[WORD_W-1]);

            // R5: mixed-sign min is signed, so an unsigned clamp never goes negative
            a_r5_clamp_low: assert property (@(posedge clk) disable iff (rst)
                (saturate && !dst_signed && (a_signed != b_signed) && !take_max && sec_op == 3'd0)
                |=> !result[WORD_W-1]);

            // R7: the upper-half merge leaves C's lower half intact
            a_r7_keep_low: assert property (@(posedge clk) disable iff (rst)
                (sec_op == 3'd4) |=> result[HALF_W-1:0] == $past(opc[HALF_W-1:0]));

            // R7: the byte-0 merge leaves C's upper 24 bits intact
            a_r7_keep_upper: assert property (@(posedge clk) disable iff (rst)
                (sec_op == 3'd6) |=> result[WORD_W-1:BYTE_W] == $past(opc[WORD_W-1:BYTE_W]));

            // R3: unsigned full-word max bounds both operands from above
            a_r3_max_bound: assert property (@(posedge clk) disable iff (rst)
                (b_from_reg && !a_signed && !b_signed && take_max && !saturate &&
                 a_lane == 3'd6 && b_lane == 3'd6 && sec_op == 3'd0)
                |=> (result >= $past(opa)) && (result >= $past(opb)));
        end else begin : g_comb
            assign result = sec_val;
        end
    endgenerate
endmodule

// File: tb/vmm_unit_bench.sv
module vmm_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa = '0, opb = '0, opc = '0;
    logic [15:0] imm = '0;
    logic        b_from_reg = 1'b1;
    logic [2:0]  a_lane = 3'd6, b_lane = 3'd6;
    logic        a_signed = 1'b0, b_signed = 1'b0;
    logic        take_max = 1'b0, saturate = 1'b0, dst_signed = 1'b0;
    logic [2:0]  sec_op = 3'd0;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vmm_unit u_vmm_unit (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .opc(opc), .imm(imm),
        .b_from_reg(b_from_reg), .a_lane(a_lane), .a_signed(a_signed),
        .b_lane(b_lane), .b_signed(b_signed), .take_max(take_max),
        .saturate(saturate), .dst_signed(dst_signed), .sec_op(sec_op),
        .result(result)
    );

    typedef struct packed {
        logic [31:0] a, b, c;
        logic [15:0] im;
        logic        bfr;
        logic [2:0]  al;
        logic        as_;
        logic [2:0]  bl;
        logic        bs;
        logic        mx, sat, ds;
        logic [2:0]  sec;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{32'h000000F0, 32'h00000005, 32'h0, 16'h0, 1'b1, 3'd0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'hFFFFFFF0},
        '{32'h000000F0, 32'h00000005, 32'h0, 16'h0, 1'b1, 3'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'h00000005},
        '{32'h12345678, 32'h0, 32'h00000002, 16'hFFFE, 1'b0, 3'd3, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 32'h00010000},
        '{32'h00000003, 32'h0, 32'h0, 16'hFFFE, 1'b0, 3'd6, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'hFFFFFFFE},
        '{32'h80000000, 32'h00000001, 32'h0, 16'h0, 1'b1, 3'd6, 1'b0, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 32'h00000000},
        '{32'hFFFFFFFF, 32'h80000000, 32'h0, 16'h0, 1'b1, 3'd6, 1'b1, 3'd6, 1'b0, 1'b1, 1'b1, 1'b1, 3'd0, 32'h7FFFFFFF},
        '{32'h0000ABCD, 32'h00001234, 32'h11223344, 16'h0, 1'b1, 3'd4, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 32'h11CD3344},
        '{32'h0000ABCD, 32'h00001234, 32'h11223344, 16'h0, 1'b1, 3'd4, 1'b0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 32'hABCD3344},
        '{32'h00000005, 32'h00000003, 32'hFFFFFFFF, 16'h0, 1'b1, 3'd6, 1'b0, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 32'h00000005},
        '{32'h00000005, 32'h00000003, 32'hFFFFFFFF, 16'h0, 1'b1, 3'd6, 1'b0, 3'd6, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 32'hFFFFFFFF}
    };

    // Independent model written from the requirements
    function automatic logic [31:0] model_lane(logic [31:0] w, logic [2:0] ln, logic s);
        logic [31:0] r;
        if (ln <= 3'd3) begin
            r = (w >> (8 * ln)) & 32'hFF;
            if (s && r[7]) r = r | 32'hFFFFFF00;
        end else if (ln == 3'd4 || ln == 3'd5) begin
            r = (ln == 3'd5) ? (w >> 16) : (w & 32'hFFFF);
            if (s && r[15]) r = r | 32'hFFFF0000;
        end else r = w;
        return r;
    endfunction

    function automatic logic [31:0] model(vec_t v);
        logic [31:0] va, vb, m, uo;
        logic        rs;
        va = model_lane(v.a, v.al, v.as_);
        vb = v.bfr ? model_lane(v.b, v.bl, v.bs)
                   : ((v.bs && v.im[15]) ? {16'hFFFF, v.im} : {16'h0000, v.im});
        if (v.as_ == v.bs) begin
            rs = v.as_;
            if (rs) m = (v.mx ^ ($signed(va) > $signed(vb))) ? vb : va;
            else    m = (v.mx ^ (va > vb)) ? vb : va;
        end else begin
            rs = !v.mx;
            if (v.mx) m = (va > vb) ? va : vb;
            else      m = ($signed(va) > $signed(vb)) ? vb : va;
            uo = v.as_ ? vb : va;
            if (uo[31]) m = uo;
        end
        if (v.sat && v.ds && !rs && m > 32'h7FFFFFFF) m = 32'h7FFFFFFF;
        if (v.sat && !v.ds && rs && $signed(m) < 0) m = 32'h0;
        case (v.sec)
            3'd1: m = m + v.c;
            3'd2: m = v.ds ? (($signed(v.c) > $signed(m)) ? v.c : m) : ((v.c > m) ? v.c : m);
            3'd3: m = v.ds ? (($signed(v.c) < $signed(m)) ? v.c : m) : ((v.c < m) ? v.c : m);
            3'd4: m = {m[15:0], v.c[15:0]};
            3'd5: m = {v.c[31:16], m[15:0]};
            3'd6: m = {v.c[31:8], m[7:0]};
            3'd7: m = {v.c[31:24], m[7:0], v.c[15:0]};
            default: ;
        endcase
        return m;
    endfunction

    task automatic drive(vec_t v);
        opa = v.a; opb = v.b; opc = v.c; imm = v.im; b_from_reg = v.bfr;
        a_lane = v.al; a_signed = v.as_; b_lane = v.bl; b_signed = v.bs;
        take_max = v.mx; saturate = v.sat; dst_signed = v.ds; sec_op = v.sec;
    endtask

    task automatic run_check(vec_t v, logic [31:0] exp, string tag);
        drive(v);
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (result !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h (sec=%0d al=%0d bl=%0d)",
                     tag, result, exp, v.sec, v.al, v.bl);
        end
    endtask

    function automatic string tag_of(vec_t v);
        if (v.sec == 3'd0) return (v.as_ != v.bs) ? "R4" : (v.bfr ? "R3" : "R2");
        if (v.sec >= 3'd4) return "R7";
        return "R6";
    endfunction

    localparam logic [31:0] EDGES [4] = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        vec_t v;
        opa = 32'hDEADBEEF; opc = 32'h12345678; sec_op = 3'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset holds result at zero
        n_chk++;
        if (result !== 32'h0) begin
            n_bad++;
            $display("FAIL R9: got %08h expected 00000000", result);
        end
        rst = 1'b0;

        // Table of hand-computed vectors (R1 R2 R3 R4 R5 R6 R7)
        for (int i = 0; i < NV; i++) begin
            run_check(TBL[i], TBL[i].exp, "R1");
            if (TBL[i].exp !== model(TBL[i])) begin
                n_bad++;
                $display("FAIL R1: got model %08h expected table %08h", model(TBL[i]), TBL[i].exp);
            end
        end

        // R9: one-cycle latency, value before the edge is still the old one
        v = TBL[1];
        drive(v);
        #1;
        n_chk++;
        if (result !== TBL[9].exp) begin
            n_bad++;
            $display("FAIL R9: got %08h expected %08h", result, TBL[9].exp);
        end
        @(posedge clk); @(negedge clk);
        n_chk++;
        if (result !== TBL[1].exp) begin
            n_bad++;
            $display("FAIL R9: got %08h expected %08h", result, TBL[1].exp);
        end

        // R4 R5: boundary words under every sign pairing and clamp setting
        for (int ia = 0; ia < 4; ia++)
            for (int ib = 0; ib < 4; ib++)
                for (int k = 0; k < 32; k++) begin
                    v = '0;
                    v.a = EDGES[ia]; v.b = EDGES[ib]; v.bfr = 1'b1;
                    v.al = 3'd6; v.bl = 3'd6;
                    v.as_ = k[0]; v.bs = k[1]; v.mx = k[2]; v.sat = k[3]; v.ds = k[4];
                    v.sec = 3'd0;
                    run_check(v, model(v), (k[3] ? "R5" : "R4"));
                end

        // R1 R6 R7 R8: every lane and secondary code with random words
        for (int s = 0; s < 8; s++)
            for (int la = 0; la < 8; la++)
                for (int lb = 0; lb < 8; lb++) begin
                    v = '0;
                    v.a = $urandom; v.b = $urandom; v.c = $urandom; v.im = 16'($urandom);
                    v.al = 3'(la); v.bl = 3'(lb); v.sec = 3'(s);
                    v.bfr = (lb != 7); v.as_ = 1'($urandom); v.bs = 1'($urandom);
                    v.mx = 1'($urandom); v.sat = 1'($urandom); v.ds = 1'($urandom);
                    run_check(v, model(v), (s == 0) ? "R8" : tag_of(v));
                end

        // R9: synchronous reset clears a nonzero result
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        n_chk++;
        if (result !== 32'h0) begin
            n_bad++;
            $display("FAIL R9: got %08h expected 00000000", result);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule